// File: doc/BRIEF.md
# Frame-synchronized pixel readout arbiter

This block drains a square group of pixels onto one shared data stream. When a frame-start pulse arrives while the block is idle, it copies the current set of pixel request flags into a frame snapshot. A binary priority tree then picks the pending pixel with the lowest index, grants it, and captures that pixel's data word into a single output slot. The tree then clears the pixel's snapshot bit, so the next pixel in order wins on the following cycle. No external strobe steps the sequence. The tree drives itself from the snapshot until the snapshot is empty. The block then emits a one-cycle end-of-frame pulse and waits for the next frame start.

There are two modes, and the mode is sampled together with the frame start. In zero-suppressed mode only flagged pixels are read. Each output word carries the winning pixel's index, which the tree produces in the same cycle as the grant. In full-frame mode every pixel is read in index order, whatever its flag. By default one instance serves 1024 pixels with 11-bit data words.

The output is a valid/ready stream. A word is transferred on a clock edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the data and the address are held steady and no new pixel is granted. A new grant can be issued in the same cycle that the held word is accepted, so the stream carries one word per cycle while `out_ready` stays high.

Top module: `pixel_frame_arbiter`

## Requirements
- R1: A `frame_start` sampled while idle loads the snapshot. In zero-suppressed mode (`mode_zs`=1) the snapshot is `pix_req`. In full-frame mode (`mode_zs`=0) it holds all pixels. The mode takes effect only at that edge.
- R2: Within a frame, words leave in strictly ascending pixel index, with index 0 having the highest priority. Every pixel in the snapshot is delivered exactly once.
- R3: In full-frame mode all N pixels are delivered, including those whose request flag is low.
- R4: Each word's `out_addr` is the pixel index, and its `out_data` is bits [i*DW +: DW] of `pix_data` for that pixel i, sampled in the grant cycle.
- R5: `pix_grant` has at most one bit set. A bit is high only in the cycle in which that pixel's data is captured. On the next cycle `out_valid` is high and `out_addr` equals the granted index.
- R6: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data` and `out_addr` hold their values and `pix_grant` stays zero.
- R7: `pix_req`, `mode_zs` and `frame_start` have no effect while a frame is being read out. The delivered sequence depends only on the snapshot.
- R8: `out_eof` is a single-cycle pulse. It rises on the edge after the last word is accepted, or on the second edge after the frame start when the snapshot is empty. The block then returns to idle.
- R9: While reset is asserted, `out_valid`, `out_eof` and `pix_grant` are low and the block is idle. Reset also abandons a frame in progress.
- R10: The first word of a non-empty frame is valid on the first edge after the edge that samples `frame_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Frame-start pulse; honoured only when idle |
| mode_zs | input | 1 | 1 = zero-suppressed, 0 = full-frame; sampled with frame_start |
| pix_req | input | N | Per-pixel hit flags |
| pix_data | input | N*DW | Per-pixel data words, pixel i at [i*DW +: DW] |
| out_ready | input | 1 | Stream sink ready |
| pix_grant | output | N | Per-pixel grant, one-hot or zero |
| out_valid | output | 1 | Stream word valid |
| out_data | output | DW | Data of the delivered pixel |
| out_addr | output | $clog2(N) | Index of the delivered pixel |
| out_eof | output | 1 | End-of-frame pulse |

## Verification
The hardest case to create is a frame already in flight with a word held by back-pressure, while the inputs try to disturb the snapshot. In that case the requests flip, the mode inverts and a second frame start arrives before the first frame has drained. Several table vectors pulse `frame_start` on the cycle after the snapshot edge. In the same cycle they invert every request flag and the mode, while `out_ready` drops periodically. The collected addresses must then still match a software scan of the original snapshot. A directed reset in the middle of a stalled frame checks that no stale snapshot bits survive into the next frame.

// File: rtl/pxarb_pkg.sv
package pxarb_pkg;
  typedef enum logic {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } scan_e;
endpackage

// File: rtl/pxarb_tree.sv
// Binary priority tree in heap layout: node k has children 2k and 2k+1,
// leaves sit at N..2N-1. "any" flows up, the winner index flows up with
// it, and the grant enable is steered down towards the lower index first.
module pxarb_tree #(
  parameter int N  = 1024,
  localparam int AW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [N-1:0]  gnt,
  output logic [AW-1:0] win
);
  logic [2*N-1:1] any_h;
  logic [2*N-1:1] en_h;
  logic [AW-1:0]  adr_h [1:2*N-1];

  for (genvar i = 0; i < N; i++) begin : g_leaf
    assign any_h[N+i] = req[i];
    assign adr_h[N+i] = AW'(i);
    assign gnt[i]     = en_h[N+i];
  end

  for (genvar k = 1; k < N; k++) begin : g_node
    assign any_h[k]     = any_h[2*k] | any_h[2*k+1];
    assign adr_h[k]     = any_h[2*k] ? adr_h[2*k] : adr_h[2*k+1];
    assign en_h[2*k]    = en_h[k] & any_h[2*k];
    assign en_h[2*k+1]  = en_h[k] & ~any_h[2*k] & any_h[2*k+1];
  end

  assign en_h[1] = any_h[1];
  assign any     = any_h[1];
  assign win     = adr_h[1];
endmodule

// File: rtl/pxarb_frame_ctl.sv
module pxarb_frame_ctl
  import pxarb_pkg::*;
#(
  parameter int N = 1024
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_start,
  input  logic         mode_zs,
  input  logic [N-1:0] pix_req,
  input  logic [N-1:0] taken,
  input  logic         snap_any,
  input  logic         drained,
  output logic [N-1:0] snap,
  output logic         busy,
  output logic         eof
);
  scan_e st;

  assign busy = (st == SCAN_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SCAN_IDLE;
      snap <= '0;
      eof  <= 1'b0;
    end else begin
      eof <= 1'b0;
      case (st)
        SCAN_IDLE: begin
          if (frame_start) begin
            snap <= mode_zs ? pix_req : '1;
            st   <= SCAN_RUN;
          end
        end
        SCAN_RUN: begin
          snap <= snap & ~taken;
          if (!snap_any && drained) begin
            st  <= SCAN_IDLE;
            eof <= 1'b1;
          end
        end
        default: st <= SCAN_IDLE;
      endcase
    end
  end

  // R1: an idle frame start always opens a frame
  a_r1_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && frame_start) |=> busy);

  // R2: a granted pixel leaves the snapshot on the next edge
  a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|taken) |=> ((snap & $past(taken)) == '0));

  // R7: during a frame the snapshot can only lose bits
  a_r7_shrink: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((snap & ~$past(snap)) == '0));

  // R8: end of frame leaves the controller idle
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> !busy);
endmodule

// File: rtl/pxarb_outreg.sv
module pxarb_outreg #(
  parameter int N  = 1024,
  parameter int DW = 11,
  localparam int AW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [AW-1:0]   sel,
  input  logic [N*DW-1:0] pix_data,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [DW-1:0]   out_data,
  output logic [AW-1:0]   out_addr,
  output logic            free
);
  logic [DW-1:0] words [N];

  for (genvar i = 0; i < N; i++) begin : g_word
    assign words[i] = pix_data[i*DW +: DW];
  end

  assign free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_addr  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= words[sel];
      out_addr  <= sel;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R6: a stalled word is held unchanged
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_addr)));

  // R6: a new word never overwrites one that has not been taken
  a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!out_valid || out_ready));
endmodule

// File: rtl/pixel_frame_arbiter.sv
module pixel_frame_arbiter #(
  parameter int N  = 1024,
  parameter int DW = 11,
  localparam int AW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic            mode_zs,
  input  logic [N-1:0]    pix_req,
  input  logic [N*DW-1:0] pix_data,
  input  logic            out_ready,
  output logic [N-1:0]    pix_grant,
  output logic            out_valid,
  output logic [DW-1:0]   out_data,
  output logic [AW-1:0]   out_addr,
  output logic            out_eof
);
  logic [N-1:0]  snap;
  logic [N-1:0]  tree_gnt;
  logic          snap_any;
  logic [AW-1:0] win;
  logic          busy;
  logic          free;
  logic          load;

  pxarb_tree #(.N(N)) u_tree (
    .req (snap),
    .any (snap_any),
    .gnt (tree_gnt),
    .win (win)
  );

  assign load      = busy & snap_any & free;
  assign pix_grant = tree_gnt & {N{load}};

  pxarb_frame_ctl #(.N(N)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .mode_zs     (mode_zs),
    .pix_req     (pix_req),
    .taken       (pix_grant),
    .snap_any    (snap_any),
    .drained     (free),
    .snap        (snap),
    .busy        (busy),
    .eof         (out_eof)
  );

  pxarb_outreg #(.N(N), .DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .sel       (win),
    .pix_data  (pix_data),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_addr  (out_addr),
    .free      (free)
  );

  // R5: at most one pixel granted per cycle
  a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pix_grant));

  // R5: the granted pixel appears on the stream on the next cycle
  a_r5_grant_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (|pix_grant) |=> (out_valid && ($past(pix_grant) == (N'(1) << out_addr))));

  // R6: no grant while the output slot is stalled
  a_r6_no_grant_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> (pix_grant == '0));

  // R2: only pixels still in the snapshot are granted
  a_r2_grant_in_snap: assert property (@(posedge clk) disable iff (!rst_n)
    ((pix_grant & ~snap) == '0));

  // R8: end of frame is a single-cycle pulse
  a_r8_eof_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |=> !out_eof);
endmodule

// File: tb/pixel_frame_arbiter_test.sv
`timescale 1ns/1ps
module pixel_frame_arbiter_test;
  localparam int N    = 16;
  localparam int DW   = 11;
  localparam int AW   = $clog2(N);
  localparam int MAXC = 4*N + 20;
  localparam int NV   = 9;

  // fields: [21] zs, [20:5] request mask, [4:1] stall period (0 = always ready), [0] disturb mid-frame
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 16'hA5C3, 4'd0, 1'b0},
    {1'b1, 16'h0001, 4'd0, 1'b0},
    {1'b1, 16'h8000, 4'd0, 1'b0},
    {1'b0, 16'h0000, 4'd0, 1'b0},
    {1'b1, 16'hFFFF, 4'd3, 1'b0},
    {1'b1, 16'h0F0F, 4'd2, 1'b1},
    {1'b0, 16'h1234, 4'd2, 1'b1},
    {1'b1, 16'h6000, 4'd0, 1'b1},
    {1'b1, 16'h0000, 4'd0, 1'b0}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            frame_start = 1'b0;
  logic            mode_zs = 1'b0;
  logic [N-1:0]    pix_req = '0;
  logic [N*DW-1:0] pix_data = '0;
  logic            out_ready = 1'b1;
  logic [N-1:0]    pix_grant;
  logic            out_valid;
  logic [DW-1:0]   out_data;
  logic [AW-1:0]   out_addr;
  logic            out_eof;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  pixel_frame_arbiter #(.N(N), .DW(DW)) uut (
    .clk (clk), .rst_n (rst_n), .frame_start (frame_start), .mode_zs (mode_zs),
    .pix_req (pix_req), .pix_data (pix_data), .out_ready (out_ready),
    .pix_grant (pix_grant), .out_valid (out_valid), .out_data (out_data),
    .out_addr (out_addr), .out_eof (out_eof)
  );

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] data_of(input int i, input int s);
    logic [31:0] t;
    t = (i*37 + s*101 + 5) ^ 32'h2A5;
    return t[DW-1:0];
  endfunction

  function automatic int nxt(input int p, input bit zs, input logic [N-1:0] r);
    for (int j = p + 1; j < N; j++)
      if (!zs || r[j]) return j;
    return N;
  endfunction

  task automatic run_frame(input bit zs, input logic [N-1:0] req, input int stall,
                           input bit mid, input int seed);
    int exp_i;
    int gexp;
    bit done;
    bit hold;
    logic [AW-1:0] h_addr;
    logic [DW-1:0] h_data;
    logic [N-1:0]  exp_g;
    exp_i = nxt(-1, zs, req);
    gexp  = exp_i;
    done  = 1'b0;
    hold  = 1'b0;
    h_addr = '0;
    h_data = '0;
    @(negedge clk);
    for (int i = 0; i < N; i++) pix_data[i*DW +: DW] = data_of(i, seed);
    pix_req = req;
    mode_zs = zs;
    out_ready = 1'b1;
    frame_start = 1'b1;
    for (int cyc = 0; cyc < MAXC && !done; cyc++) begin
      @(negedge clk);
      frame_start = mid && (cyc == 0);
      if (mid && cyc == 0) begin
        pix_req = ~req;      // R7: must not reach the snapshot
        mode_zs = ~zs;
      end
      out_ready = (stall == 0) || ((cyc % stall) != 0);
      #1;
      if (cyc == 0) chk(!out_valid && !out_eof, "R10", "idle right after snapshot edge", int'(out_valid), 0);
      if (cyc == 1 && exp_i < N) chk(out_valid, "R10", "first word latency", int'(out_valid), 1);
      if (cyc == 1 && exp_i == N) chk(out_eof, "R8", "empty frame eof timing", int'(out_eof), 1);
      if (hold) begin
        chk(out_valid && out_addr == h_addr && out_data == h_data, "R6",
            "stalled word held", int'(out_addr), int'(h_addr));
      end
      if (out_valid && !out_ready)
        chk(pix_grant == '0, "R6", "no grant while stalled", int'(pix_grant), 0);
      if (pix_grant != '0) begin
        exp_g = (gexp < N) ? (N'(1) << gexp) : '0;
        chk(pix_grant == exp_g, "R5", "grant one-hot at expected pixel", int'(pix_grant), int'(exp_g));
        gexp = nxt(gexp, zs, req);
      end
      hold   = out_valid && !out_ready;
      h_addr = out_addr;
      h_data = out_data;
      if (out_eof) begin
        chk(exp_i == N && !out_valid, "R8", "eof only after last word", exp_i, N);
        done = 1'b1;
      end else if (out_valid && out_ready) begin
        chk(int'(out_addr) == exp_i, zs ? "R4" : "R3", "delivered address", int'(out_addr), exp_i);
        chk(out_data == data_of(exp_i, seed), "R4", "delivered data", int'(out_data),
            int'(data_of(exp_i, seed)));
        chk(exp_i < N, "R2", "no extra word", int'(out_addr), N);
        exp_i = nxt(exp_i, zs, req);
      end
    end
    chk(done, "R8", "end of frame seen", int'(done), 1);
    frame_start = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    #1;
    chk(!out_eof && !out_valid, "R8", "eof single cycle, stream idle", int'(out_eof), 0);
  endtask

  initial begin
    #2_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && !out_eof && pix_grant == '0, "R9", "outputs low in reset",
        int'(out_valid) + int'(out_eof), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!out_valid && pix_grant == '0, "R9", "idle after reset release", int'(out_valid), 0);

    // table of vectors (R1, R2, R3, R4, R7 on the disturbed entries)
    for (int v = 0; v < NV; v++) begin
      run_frame(VEC[v][21], VEC[v][20:5], int'(VEC[v][4:1]), VEC[v][0], v);
    end

    // R9: reset during a stalled frame abandons it
    @(negedge clk);
    pix_req = '1;
    mode_zs = 1'b1;
    out_ready = 1'b0;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(out_valid, "R6", "word waiting under back-pressure", int'(out_valid), 1);
    rst_n = 1'b0;
    #1;
    chk(!out_valid && !out_eof && pix_grant == '0, "R9", "reset clears mid-frame",
        int'(out_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && pix_grant == '0, "R9", "no stale snapshot after reset", int'(out_valid), 0);

    // R1: mode sampled at frame start; full-frame ignores flags
    run_frame(1'b0, 16'h0000, 0, 1'b0, 11);
    run_frame(1'b1, 16'h8421, 2, 1'b0, 12);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule